// File: doc/BRIEF.md
# Event Interrupt Controller

This block gathers up to 96 asynchronous event lines, organised as three banks of 32, and produces one level-high interrupt per line. Each line is fixed at build time as one of two kinds. A configurable line is synchronised, checked for rising and falling edges, and latched into separate rising and falling pending flags. A direct line skips the edge and pending logic, so its synchronised level goes straight to the output, gated only by the mask.

Software controls the block through a plain 32-bit register port with a write strobe, a byte address, write data and combinational read data. Per bank it can choose which edge polarities latch, mask lines, raise events in software, clear pending flags by writing 1, and keep a secure-reservation word. Per event it can hold an ownership word. A read-only word reports the width of the owner identifier.

Two resets are provided. A warm reset clears only the synchroniser and pending state, so the trigger selects, masks, secure words and ownership words survive it. A cold reset clears everything.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Event n belongs to bank n/32 at bit n mod 32. Bank b (b = 0,1,2) places its registers at these offsets: rising-select 0x20*b, falling-select 0x20*b+0x04, software event 0x20*b+0x08, rising pending 0x20*b+0x0C, falling pending 0x20*b+0x10, secure word 0x20*b+0x14, and mask 0x80+0x10*b. The select, secure and mask registers read back what was written.
- R2: An edge on a configurable line sets its rising-pending bit if that bit's rising-select is 1, and sets its falling-pending bit if that bit's falling-select is 1. The flag is visible after the third rising clock edge following the input change, because the input passes through two synchroniser flops and then the pending flop.
- R3: Writing 1 to a pending bit clears it. Writing 0 to a pending bit leaves it unchanged.
- R4: If an edge is detected on a bit in the same cycle that a write of 1 clears that bit, the bit stays set.
- R5: Writing 1 to a bit of the software event register sets that bit's rising pending flag if its rising-select is 1, and its falling pending flag if its falling-select is 1. The effect is visible one cycle after the write. The software event register always reads 0, and a software event on a direct line has no effect.
- R6: The interrupt of a configurable line is (rising pending OR falling pending) AND mask. Clearing a mask bit drops the interrupt but leaves the pending flags unchanged.
- R7: The interrupt of a direct line is its synchronised level AND mask, visible after the second clock edge following the input change. The pending bits of a direct line always read 0. Each bank's type word, with 1 meaning configurable, reads at 0x3EC, 0x3E8 and 0x3E4 for banks 0, 1 and 2.
- R8: The ownership word of event n sits at 0x180+4*n. Only bit 0 (enable) and bits 6:4 (owner ID) are stored, and every other bit reads 0.
- R9: The read-only word at 0x3F0 reports the owner-ID width in bits 27:24, which is 3 by default, and 0 in every other bit.
- R10: A warm reset clears all pending flags and leaves the selects, masks, secure words and ownership words unchanged. A cold reset clears every register, and all interrupts are low after it.
- R11: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Synchronous active-low full reset |
| warm_rst_n | input | 1 | Synchronous active-low reset of synchroniser and pending state |
| evt_in | input | 96 | Asynchronous event lines |
| irq_out | output | 96 | Level-high interrupt per event |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
Register writes, including clears and software events, take effect at the clock edge that samples the strobe. Read data follows the address in the same cycle. A configurable line's interrupt rises at the third edge after its input changes, and a direct line's at the second. The bench drives inputs and samples outputs on falling edges. At those latency boundaries it checks both the cycle before the result is due, where the output must still be low, and the cycle the result is due. It places a clearing write exactly on the edge where a pending flag is being set.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] HWCFG_ADDR = 12'h3F0;
  localparam logic [ADDR_W-1:0] OWN_BASE   = 12'h180;

  typedef enum logic [2:0] {
    SEL_RTRIG, SEL_FTRIG, SEL_SWEV, SEL_RPEND,
    SEL_FPEND, SEL_SECURE, SEL_MASK, SEL_TYPE
  } bank_reg_e;

  // byte address of a per-bank register
  function automatic logic [ADDR_W-1:0] bank_reg_addr(input int bank, input bank_reg_e r);
    case (r)
      SEL_RTRIG:  return ADDR_W'(bank * 32 + 'h00);
      SEL_FTRIG:  return ADDR_W'(bank * 32 + 'h04);
      SEL_SWEV:   return ADDR_W'(bank * 32 + 'h08);
      SEL_RPEND:  return ADDR_W'(bank * 32 + 'h0C);
      SEL_FPEND:  return ADDR_W'(bank * 32 + 'h10);
      SEL_SECURE: return ADDR_W'(bank * 32 + 'h14);
      SEL_MASK:   return ADDR_W'('h80 + bank * 16);
      default:    return ADDR_W'('h3EC - bank * 4);
    endcase
  endfunction
endpackage

// File: rtl/evt_irq_sync.sv
module evt_irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;
  assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/evt_irq_bank.sv
module evt_irq_bank #(
  parameter int         W         = 32,
  parameter logic [W-1:0] TYPE_MASK = '1
) (
  input  logic         clk,
  input  logic         cold_rst_n,
  input  logic         warm_rst_n,
  input  logic [W-1:0] evt_in,
  input  logic         wr_rtrig,
  input  logic         wr_ftrig,
  input  logic         wr_swev,
  input  logic         wr_rpend,
  input  logic         wr_fpend,
  input  logic         wr_secure,
  input  logic         wr_mask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rtrig,
  output logic [W-1:0] ftrig,
  output logic [W-1:0] secure,
  output logic [W-1:0] mask,
  output logic [W-1:0] rpend,
  output logic [W-1:0] fpend,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall,
  output logic [W-1:0] irq
);
  logic         clr;
  logic [W-1:0] level;

  assign clr = !cold_rst_n || !warm_rst_n;

  // retained configuration: only a cold reset clears it
  always_ff @(posedge clk) begin
    if (!cold_rst_n) begin
      rtrig  <= '0;
      ftrig  <= '0;
      secure <= '0;
      mask   <= '0;
    end else begin
      if (wr_rtrig)  rtrig  <= wdata;
      if (wr_ftrig)  ftrig  <= wdata;
      if (wr_secure) secure <= wdata;
      if (wr_mask)   mask   <= wdata;
    end
  end

  evt_irq_sync #(.W(W)) u_sync (
    .clk   (clk),
    .clr   (clr),
    .din   (evt_in),
    .level (level),
    .rise  (rise),
    .fall  (fall)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (TYPE_MASK[i]) begin : g_cfg
      logic rp_q, fp_q;
      logic set_r, set_f;
      assign set_r = rtrig[i] && (rise[i] || (wr_swev && wdata[i]));
      assign set_f = ftrig[i] && (fall[i] || (wr_swev && wdata[i]));
      // a set in the same cycle as a clear wins
      always_ff @(posedge clk) begin
        if (clr) begin
          rp_q <= 1'b0;
          fp_q <= 1'b0;
        end else begin
          if (set_r)                    rp_q <= 1'b1;
          else if (wr_rpend && wdata[i]) rp_q <= 1'b0;
          if (set_f)                    fp_q <= 1'b1;
          else if (wr_fpend && wdata[i]) fp_q <= 1'b0;
        end
      end
      assign rpend[i] = rp_q;
      assign fpend[i] = fp_q;
      assign irq[i]   = (rp_q | fp_q) & mask[i];
    end else begin : g_dir
      assign rpend[i] = 1'b0;
      assign fpend[i] = 1'b0;
      assign irq[i]   = level[i] & mask[i];
    end
  end
endmodule

// File: rtl/evt_irq_own.sv
module evt_irq_own #(
  parameter int NUM_EVT = 96,
  parameter int ID_W    = 3,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_EVT),
  localparam int CELL_W = ID_W + 1
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              wr_en,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [CELL_W-1:0] wcell,
  output logic [DATA_W-1:0] rdata
);
  if (ID_W == 0) begin : g_absent
    assign rdata = '0;
  end else begin : g_store
    logic [CELL_W-1:0] cell_q [NUM_EVT];

    always_ff @(posedge clk) begin
      if (!cold_rst_n) begin
        for (int k = 0; k < NUM_EVT; k++) cell_q[k] <= '0;
      end else if (wr_en && hit) begin
        cell_q[idx] <= wcell;
      end
    end

    // enable at bit 0, owner ID from bit 4 upward
    always_comb begin
      rdata = '0;
      if (hit) begin
        rdata[0] = cell_q[idx][0];
        for (int k = 0; k < ID_W; k++) rdata[4+k] = cell_q[idx][k+1];
      end
    end
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int NUM_BANKS  = 3,
  parameter int OWNER_ID_W = 3,
  parameter logic [NUM_BANKS*REG_W-1:0] TRIG_TYPE = {32'h0000_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
) (
  input  logic                       clk,
  input  logic                       cold_rst_n,
  input  logic                       warm_rst_n,
  input  logic [NUM_BANKS*REG_W-1:0] evt_in,
  output logic [NUM_BANKS*REG_W-1:0] irq_out,
  input  logic                       reg_wr_en,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [REG_W-1:0]           reg_wdata,
  output logic [REG_W-1:0]           reg_rdata
);
  localparam int NUM_EVT = NUM_BANKS * REG_W;
  localparam int IDX_W   = $clog2(NUM_EVT);
  localparam int CELL_W  = OWNER_ID_W + 1;
  localparam logic [REG_W-1:0] HWCFG = REG_W'(OWNER_ID_W) << 24;

  logic [NUM_BANKS-1:0][REG_W-1:0] rtrig_q, ftrig_q, secure_q, mask_q;
  logic [NUM_BANKS-1:0][REG_W-1:0] rpend_q, fpend_q, rise_q, fall_q, irq_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    evt_irq_bank #(
      .W         (REG_W),
      .TYPE_MASK (TRIG_TYPE[b*REG_W +: REG_W])
    ) u_bank (
      .clk        (clk),
      .cold_rst_n (cold_rst_n),
      .warm_rst_n (warm_rst_n),
      .evt_in     (evt_in[b*REG_W +: REG_W]),
      .wr_rtrig   (reg_wr_en && reg_addr == bank_reg_addr(b, SEL_RTRIG)),
      .wr_ftrig   (reg_wr_en && reg_addr == bank_reg_addr(b, SEL_FTRIG)),
      .wr_swev    (reg_wr_en && reg_addr == bank_reg_addr(b, SEL_SWEV)),
      .wr_rpend   (reg_wr_en && reg_addr == bank_reg_addr(b, SEL_RPEND)),
      .wr_fpend   (reg_wr_en && reg_addr == bank_reg_addr(b, SEL_FPEND)),
      .wr_secure  (reg_wr_en && reg_addr == bank_reg_addr(b, SEL_SECURE)),
      .wr_mask    (reg_wr_en && reg_addr == bank_reg_addr(b, SEL_MASK)),
      .wdata      (reg_wdata),
      .rtrig      (rtrig_q[b]),
      .ftrig      (ftrig_q[b]),
      .secure     (secure_q[b]),
      .mask       (mask_q[b]),
      .rpend      (rpend_q[b]),
      .fpend      (fpend_q[b]),
      .rise       (rise_q[b]),
      .fall       (fall_q[b]),
      .irq        (irq_q[b])
    );
  end

  assign irq_out = irq_q;

  // ownership window decode
  logic [ADDR_W-1:0] own_off;
  logic              own_hit;
  logic [IDX_W-1:0]  own_idx;
  logic [CELL_W-1:0] own_wcell;
  logic [REG_W-1:0]  own_rdata;

  assign own_off = reg_addr - OWN_BASE;
  assign own_hit = (reg_addr >= OWN_BASE) && (own_off < ADDR_W'(4 * NUM_EVT)) && (own_off[1:0] == 2'b00);
  assign own_idx = own_off[IDX_W+1:2];

  always_comb begin
    own_wcell[0] = reg_wdata[0];
    for (int k = 0; k < OWNER_ID_W; k++) own_wcell[k+1] = reg_wdata[4+k];
  end

  evt_irq_own #(
    .NUM_EVT (NUM_EVT),
    .ID_W    (OWNER_ID_W),
    .DATA_W  (REG_W)
  ) u_own (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .wr_en      (reg_wr_en),
    .hit        (own_hit),
    .idx        (own_idx),
    .wcell      (own_wcell),
    .rdata      (own_rdata)
  );

  // read mux; software event offsets fall through to 0
  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr == bank_reg_addr(b, SEL_RTRIG))  reg_rdata = rtrig_q[b];
      if (reg_addr == bank_reg_addr(b, SEL_FTRIG))  reg_rdata = ftrig_q[b];
      if (reg_addr == bank_reg_addr(b, SEL_RPEND))  reg_rdata = rpend_q[b];
      if (reg_addr == bank_reg_addr(b, SEL_FPEND))  reg_rdata = fpend_q[b];
      if (reg_addr == bank_reg_addr(b, SEL_SECURE)) reg_rdata = secure_q[b];
      if (reg_addr == bank_reg_addr(b, SEL_MASK))   reg_rdata = mask_q[b];
      if (reg_addr == bank_reg_addr(b, SEL_TYPE))   reg_rdata = TRIG_TYPE[b*REG_W +: REG_W];
    end
    if (reg_addr == HWCFG_ADDR) reg_rdata = HWCFG;
    if (own_hit)                reg_rdata = own_rdata;
  end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk
  import evt_irq_pkg::*;
#(
  parameter int NUM_BANKS  = 3,
  parameter int OWNER_ID_W = 3,
  parameter logic [NUM_BANKS*REG_W-1:0] TRIG_TYPE = '1
) (
  input logic                       clk,
  input logic                       cold_rst_n,
  input logic                       warm_rst_n,
  input logic                       reg_wr_en,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [REG_W-1:0]           reg_wdata,
  input logic [REG_W-1:0]           reg_rdata,
  input logic [NUM_BANKS*REG_W-1:0] irq_out,
  input logic [NUM_BANKS*REG_W-1:0] mask_q,
  input logic [NUM_BANKS*REG_W-1:0] rtrig_q,
  input logic [NUM_BANKS*REG_W-1:0] ftrig_q,
  input logic [NUM_BANKS*REG_W-1:0] rpend_q,
  input logic [NUM_BANKS*REG_W-1:0] fpend_q,
  input logic [NUM_BANKS*REG_W-1:0] rise_q,
  input logic [NUM_BANKS*REG_W-1:0] fall_q
);
  localparam int NUM_EVT = NUM_BANKS * REG_W;

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    (irq_out & ~mask_q) == '0);

  assert_direct_no_pend_R7: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    ((rpend_q | fpend_q) & ~TRIG_TYPE) == '0);

  assert_swev_reads_zero_R5: assert property (@(posedge clk) disable iff (!cold_rst_n)
    reg_addr == bank_reg_addr(0, SEL_SWEV) |-> reg_rdata == '0);

  assert_hwcfg_R9: assert property (@(posedge clk) disable iff (!cold_rst_n)
    reg_addr == HWCFG_ADDR |-> reg_rdata[27:24] == 4'(OWNER_ID_W));

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    localparam int B = i / REG_W;
    localparam int K = i % REG_W;
    if (TRIG_TYPE[i]) begin : g_cfg
      logic clr_r, clr_f;
      assign clr_r = reg_wr_en && reg_addr == bank_reg_addr(B, SEL_RPEND) && reg_wdata[K];
      assign clr_f = reg_wr_en && reg_addr == bank_reg_addr(B, SEL_FPEND) && reg_wdata[K];

      assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        rise_q[i] && rtrig_q[i] |=> rpend_q[i]);
      assert_fall_sets_R2: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        fall_q[i] && ftrig_q[i] |=> fpend_q[i]);
      assert_edge_beats_clear_R4: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        rise_q[i] && rtrig_q[i] && clr_r |=> rpend_q[i]);
      assert_pend_holds_R3: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        rpend_q[i] && !clr_r |=> rpend_q[i]);
      assert_fpend_holds_R3: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        fpend_q[i] && !clr_f |=> fpend_q[i]);
    end
  end
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
  .NUM_BANKS  (NUM_BANKS),
  .OWNER_ID_W (OWNER_ID_W),
  .TRIG_TYPE  (TRIG_TYPE)
) chk_i (.*);

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;
  typedef struct packed {
    logic        rd;
    logic [3:0]  req;
    logic [11:0] addr;
    logic [31:0] val;
  } vec_t;

  // rd=0: write val; rd=1: read and expect val
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd1,  12'h000, 32'hA5A5_0001},  // R1 rising select bank 0
    '{1'b1, 4'd1,  12'h000, 32'hA5A5_0001},
    '{1'b0, 4'd1,  12'h024, 32'h0F0F_F0F0},  // R1 falling select bank 1
    '{1'b1, 4'd1,  12'h024, 32'h0F0F_F0F0},
    '{1'b0, 4'd1,  12'h054, 32'h1234_5678},  // R1 secure word bank 2
    '{1'b1, 4'd1,  12'h054, 32'h1234_5678},
    '{1'b0, 4'd1,  12'h090, 32'hFFFF_0000},  // R1 mask bank 1
    '{1'b1, 4'd1,  12'h090, 32'hFFFF_0000},
    '{1'b0, 4'd5,  12'h008, 32'hFFFF_FFFF},  // R5 software event bank 0
    '{1'b1, 4'd5,  12'h008, 32'h0000_0000},
    '{1'b1, 4'd5,  12'h00C, 32'hA5A5_0001},
    '{1'b1, 4'd5,  12'h010, 32'h0000_0000},
    '{1'b0, 4'd3,  12'h00C, 32'hFFFF_FFFF},  // R3 clear all
    '{1'b1, 4'd3,  12'h00C, 32'h0000_0000},
    '{1'b1, 4'd7,  12'h3EC, 32'hFFFF_FFFF},  // R7 type words
    '{1'b1, 4'd7,  12'h3E4, 32'h0000_FFFF},
    '{1'b1, 4'd9,  12'h3F0, 32'h0300_0000},  // R9 config word
    '{1'b0, 4'd8,  12'h184, 32'hFFFF_FFFF},  // R8 ownership event 1
    '{1'b1, 4'd8,  12'h184, 32'h0000_0071},
    '{1'b0, 4'd11, 12'h018, 32'hFFFF_FFFF},  // R11 unmapped
    '{1'b1, 4'd11, 12'h018, 32'h0000_0000},
    '{1'b1, 4'd11, 12'h014, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        cold_rst_n = 1'b0;
  logic        warm_rst_n = 1'b1;
  logic [95:0] evt_in = '0;
  logic [95:0] irq_out;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int          checks = 0;
  int          failures = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  evt_irq_ctrl dut_i (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .warm_rst_n (warm_rst_n),
    .evt_in     (evt_in),
    .irq_out    (irq_out),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    cold_rst_n = 1'b1;
    idle(1);
    // R10 reset state
    chk("R10 irq after cold reset", 32'(|irq_out), 32'd0);
    rd(12'h090, v); chk("R10 mask after cold reset", v, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        rd(VEC[i].addr, v);
        chk($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].val);
      end else begin
        wr(VEC[i].addr, VEC[i].val);
      end
    end

    // R2 edge latching and latency
    wr(12'h000, 32'h08);
    wr(12'h004, 32'h10);
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h080, 32'h18);
    evt_in[3] = 1'b1; evt_in[4] = 1'b1;
    idle(2);
    chk("R2 irq3 not yet due", 32'(irq_out[3]), 32'd0);
    idle(1);
    chk("R2 irq3 on third edge", 32'(irq_out[3]), 32'd1);
    chk("R2 rise on falling-only bit", 32'(irq_out[4]), 32'd0);
    evt_in[3] = 1'b0; evt_in[4] = 1'b0;
    idle(3);
    rd(12'h010, v); chk("R2 falling pending", v, 32'h10);
    rd(12'h00C, v); chk("R2 rising pending", v, 32'h08);
    chk("R6 irq4 from falling pending", 32'(irq_out[4]), 32'd1);

    // R6 mask gating keeps pending
    wr(12'h080, 32'h0);
    chk("R6 masked irq3", 32'(irq_out[3]), 32'd0);
    rd(12'h00C, v); chk("R6 pending kept under mask", v, 32'h08);
    wr(12'h080, 32'h18);
    chk("R6 unmasked irq3", 32'(irq_out[3]), 32'd1);

    // R3 write-one-to-clear
    wr(12'h00C, 32'h0);
    rd(12'h00C, v); chk("R3 write 0 no effect", v, 32'h08);
    wr(12'h00C, 32'h08);
    rd(12'h00C, v); chk("R3 write 1 clears", v, 32'h0);
    chk("R3 irq3 after clear", 32'(irq_out[3]), 32'd0);
    wr(12'h010, 32'h10);

    // R4 edge in the same cycle as clear
    evt_in[3] = 1'b1;
    idle(2);
    wr(12'h00C, 32'h08);
    rd(12'h00C, v); chk("R4 edge wins over clear", v, 32'h08);

    // R5 software events
    wr(12'h000, 32'h20);
    wr(12'h004, 32'h40);
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h008, 32'hE0);
    rd(12'h00C, v); chk("R5 sw rising pending", v, 32'h20);
    rd(12'h010, v); chk("R5 sw falling pending", v, 32'h40);
    wr(12'h040, 32'h0001_0000);
    wr(12'h048, 32'h0001_0000);
    rd(12'h04C, v); chk("R5 sw on direct line ignored", v, 32'h0);

    // R7 direct line
    wr(12'h0A0, 32'h0001_0000);
    evt_in[80] = 1'b1;
    idle(1);
    chk("R7 direct not yet due", 32'(irq_out[80]), 32'd0);
    idle(1);
    chk("R7 direct on second edge", 32'(irq_out[80]), 32'd1);
    rd(12'h04C, v); chk("R7 direct no pending", v, 32'h0);
    wr(12'h0A0, 32'h0);
    chk("R7 direct masked", 32'(irq_out[80]), 32'd0);
    evt_in[80] = 1'b0;

    // R1 bank mapping: event 40 is bank 1 bit 8
    wr(12'h020, 32'h100);
    evt_in[40] = 1'b1;
    idle(3);
    rd(12'h02C, v); chk("R1 event 40 in bank 1", v, 32'h100);
    rd(12'h00C, v); chk("R1 bank 0 untouched", v, 32'h20);

    // R10 warm then cold reset
    evt_in = '0;
    idle(4);
    warm_rst_n = 1'b0;
    idle(1);
    warm_rst_n = 1'b1;
    rd(12'h00C, v); chk("R10 warm clears pending", v, 32'h0);
    rd(12'h02C, v); chk("R10 warm clears bank 1 pending", v, 32'h0);
    rd(12'h080, v); chk("R10 warm keeps mask", v, 32'h18);
    rd(12'h000, v); chk("R10 warm keeps select", v, 32'h20);
    rd(12'h184, v); chk("R10 warm keeps ownership", v, 32'h71);
    rd(12'h054, v); chk("R10 warm keeps secure", v, 32'h1234_5678);
    cold_rst_n = 1'b0;
    idle(1);
    cold_rst_n = 1'b1;
    rd(12'h000, v); chk("R10 cold clears select", v, 32'h0);
    rd(12'h080, v); chk("R10 cold clears mask", v, 32'h0);
    rd(12'h184, v); chk("R10 cold clears ownership", v, 32'h0);
    rd(12'h054, v); chk("R10 cold clears secure", v, 32'h0);
    chk("R10 irq after cold", 32'(|irq_out), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule